// File: doc/BRIEF.md
# Cascaded Rotating-Priority Interrupt Resolver

This block resolves sixteen interrupt lines through two eight-input request stages, a primary and a secondary, where the secondary stage reports into primary input 2. Each line has its own set pulse, clear pulse and trigger-type select. Request, in-service and activity state is held in registers. A combinational pending flag tells the host that something unmasked is waiting.

When the host strobes acknowledge, each stage scans its inputs circularly. The scan starts one position above a programmable lowest-priority pointer. The primary stage is scanned first, and its cascade input is never granted on its own account. The winning line moves from request to in-service. Its vector is its stage's base plus its index. That vector, or all ones when nothing qualifies, is presented in a register together with a one-cycle valid pulse.

Masks, vector bases and lowest-priority pointers are plain inputs, held by whatever programming logic surrounds the block.

Top module: `cascade_irq_resolver`

## Requirements
- R1: A set pulse on line n (0..7) sets primary request bit n. A set pulse on line n (8..15) sets secondary request bit n-8 and also primary request bit 2. All changes are visible the cycle after the pulse.
- R2: A clear pulse on line n clears its request bit only when level_sel[n] is 1 (level type). With level_sel[n] at 0 (edge type), the request stays until it is granted.
- R3: When a level-type clear on a line 8..15 leaves the secondary request register at zero, primary request bit 2 is cleared in the same update.
- R4: pending is 1 exactly when the primary request register has an unmasked bit other than bit 2, or the secondary request register has an unmasked bit. A mask bit of 1 blocks its line.
- R5: On acknowledge, each stage scans indices (low+1) mod 8, (low+2) mod 8, and so on through all eight positions. The primary stage goes first and its index 2 is skipped. The secondary stage is scanned only if the primary stage has no winner.
- R6: A primary grant of index i clears primary request bit i, sets primary in-service bit i, and returns mst_base + i, zero-extended to 16 bits.
- R7: A secondary grant of index i clears secondary request bit i and primary request bit 2, sets secondary in-service bit i and primary in-service bit 2, and returns slv_base + i.
- R8: An acknowledge with no eligible request returns 16'hFFFF and leaves all request and in-service bits unchanged. The same holds when neither stage has an active flag.
- R9: ack_valid pulses high for exactly the cycle after each acknowledge strobe. ack_vector holds its last value otherwise.
- R10: Within one cycle, the grant is applied first, then level-type clears, then set pulses. A line that is granted and set in the same cycle is therefore left requesting.
- R11: Synchronous reset clears all request and in-service bits, drives ack_valid to 0 and ack_vector to 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_set | input | 16 | Per-line request set pulses |
| line_clr | input | 16 | Per-line request clear pulses |
| level_sel | input | 16 | Per-line trigger type, 1 = level, 0 = edge |
| mst_mask | input | 8 | Primary stage mask, 1 = blocked |
| slv_mask | input | 8 | Secondary stage mask, 1 = blocked |
| mst_base | input | 8 | Primary stage vector base |
| slv_base | input | 8 | Secondary stage vector base |
| mst_low | input | 3 | Primary lowest-priority index |
| slv_low | input | 3 | Secondary lowest-priority index |
| ack_req | input | 1 | Single-cycle acknowledge strobe |
| pending | output | 1 | An unmasked request is waiting |
| ack_valid | output | 1 | Vector valid pulse |
| ack_vector | output | 16 | Granted vector or 16'hFFFF |
| mst_req | output | 8 | Primary request register |
| slv_req | output | 8 | Secondary request register |
| mst_isr | output | 8 | Primary in-service register |
| slv_isr | output | 8 | Secondary in-service register |

## Verification
The bench builds the block with its defaults: eight inputs per stage, cascade on index 2, 8-bit bases and 16-bit vectors. This keeps the search space small enough to sweep. Every lowest-priority pointer is combined with every single line, so each wrap-around start point, the skipped cascade index and the secondary path are all reached. A secondary base near the top of the byte range pushes the sum past 8 bits. Full-load drains under varying masks, plus a long pseudo-random mix of set, clear and acknowledge, exercise the ordering within a cycle against an arithmetic model.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

  typedef enum logic [1:0] {
    GR_NONE = 2'd0,
    GR_MST  = 2'd1,
    GR_SLV  = 2'd2
  } grant_e;

endpackage

// File: rtl/rot_pick.sv
module rot_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  block_i,
  input  logic [IW-1:0] low_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);

  logic [N-1:0] elig;
  assign elig = req_i & ~block_i;

  // circular scan starting one above the lowest-priority index
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int k = 0; k < N; k++) begin
      int p;
      p = int'(low_i) + 1 + k;
      if (p >= N) p = p - N;
      if (p >= N) p = p - N;
      if (!hit_o && elig[p]) begin
        hit_o = 1'b1;
        idx_o = IW'(p);
      end
    end
  end

endmodule

// File: rtl/vec_out_reg.sv
module vec_out_reg #(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      vec_o   <= '1;
    end else begin
      valid_o <= fire_i;
      if (fire_i) vec_o <= vec_i;
    end
  end

endmodule

// File: rtl/cascade_irq_resolver.sv
module cascade_irq_resolver
  import cirq_pkg::*;
#(
  parameter int N      = 8,
  parameter int CASC   = 2,
  parameter int BASE_W = 8,
  parameter int VEC_W  = 16,
  localparam int IW    = $clog2(N),
  localparam int L     = 2 * N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [L-1:0]      line_set,
  input  logic [L-1:0]      line_clr,
  input  logic [L-1:0]      level_sel,
  input  logic [N-1:0]      mst_mask,
  input  logic [N-1:0]      slv_mask,
  input  logic [BASE_W-1:0] mst_base,
  input  logic [BASE_W-1:0] slv_base,
  input  logic [IW-1:0]     mst_low,
  input  logic [IW-1:0]     slv_low,
  input  logic              ack_req,
  output logic              pending,
  output logic              ack_valid,
  output logic [VEC_W-1:0]  ack_vector,
  output logic [N-1:0]      mst_req,
  output logic [N-1:0]      slv_req,
  output logic [N-1:0]      mst_isr,
  output logic [N-1:0]      slv_isr
);

  localparam logic [N-1:0] CASC_BIT = N'(1) << CASC;

  logic [N-1:0] m_req_q, s_req_q, m_isr_q, s_isr_q;
  logic         m_flag_q, s_flag_q;

  logic [N-1:0] m_req_d, s_req_d, m_isr_d, s_isr_d;
  logic         m_flag_d, s_flag_d;

  logic          m_hit, s_hit;
  logic [IW-1:0] m_idx, s_idx;
  grant_e        gsel;
  logic [VEC_W-1:0] vec_d;

  rot_pick #(.N(N)) u_mpick (
    .req_i  (m_req_q),
    .block_i(mst_mask | CASC_BIT),
    .low_i  (mst_low),
    .hit_o  (m_hit),
    .idx_o  (m_idx)
  );

  rot_pick #(.N(N)) u_spick (
    .req_i  (s_req_q),
    .block_i(slv_mask),
    .low_i  (slv_low),
    .hit_o  (s_hit),
    .idx_o  (s_idx)
  );

  always_comb begin
    logic [N-1:0] m_gbit, s_gbit, m_clr, s_clr;
    gsel = GR_NONE;
    if (ack_req && (m_flag_q || s_flag_q)) begin
      if (m_hit)      gsel = GR_MST;
      else if (s_hit) gsel = GR_SLV;
    end

    m_gbit = '0;
    s_gbit = '0;
    vec_d  = '1;
    if (gsel == GR_MST) begin
      m_gbit[m_idx] = 1'b1;
      vec_d = VEC_W'(mst_base) + VEC_W'(m_idx);
    end else if (gsel == GR_SLV) begin
      s_gbit[s_idx] = 1'b1;
      m_gbit        = CASC_BIT;
      vec_d = VEC_W'(slv_base) + VEC_W'(s_idx);
    end

    // stage 1: grant
    m_req_d  = m_req_q & ~m_gbit;
    s_req_d  = s_req_q & ~s_gbit;
    m_isr_d  = m_isr_q | m_gbit;
    s_isr_d  = s_isr_q | s_gbit;
    m_flag_d = m_flag_q;
    s_flag_d = s_flag_q;
    if (gsel == GR_MST && m_req_d == '0) m_flag_d = 1'b0;
    if (gsel == GR_SLV && s_req_d == '0) begin
      s_flag_d = 1'b0;
      if (m_req_d == '0) m_flag_d = 1'b0;
    end

    // stage 2: level-type clears
    m_clr   = line_clr[N-1:0] & level_sel[N-1:0];
    s_clr   = line_clr[L-1:N] & level_sel[L-1:N];
    m_req_d = m_req_d & ~m_clr;
    s_req_d = s_req_d & ~s_clr;
    if ((|s_clr) && s_req_d == '0) m_req_d = m_req_d & ~CASC_BIT;

    // stage 3: new requests
    s_req_d = s_req_d | line_set[L-1:N];
    m_req_d = m_req_d | line_set[N-1:0] | ((|line_set[L-1:N]) ? CASC_BIT : '0);
    if (|line_set)         m_flag_d = 1'b1;
    if (|line_set[L-1:N])  s_flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_req_q  <= '0;
      s_req_q  <= '0;
      m_isr_q  <= '0;
      s_isr_q  <= '0;
      m_flag_q <= 1'b0;
      s_flag_q <= 1'b0;
    end else begin
      m_req_q  <= m_req_d;
      s_req_q  <= s_req_d;
      m_isr_q  <= m_isr_d;
      s_isr_q  <= s_isr_d;
      m_flag_q <= m_flag_d;
      s_flag_q <= s_flag_d;
    end
  end

  vec_out_reg #(.VEC_W(VEC_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .fire_i (ack_req),
    .vec_i  (vec_d),
    .valid_o(ack_valid),
    .vec_o  (ack_vector)
  );

  assign pending = (|(m_req_q & ~mst_mask & ~CASC_BIT)) | (|(s_req_q & ~slv_mask));
  assign mst_req = m_req_q;
  assign slv_req = s_req_q;
  assign mst_isr = m_isr_q;
  assign slv_isr = s_isr_q;

endmodule

// File: rtl/cascade_irq_resolver_chk.sv
module cascade_irq_resolver_chk #(
  parameter int N     = 8,
  parameter int CASC  = 2,
  parameter int VEC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ack_req,
  input logic             ack_valid,
  input logic [VEC_W-1:0] ack_vector,
  input logic             pending,
  input logic [N-1:0]     mst_req,
  input logic [N-1:0]     slv_req,
  input logic [N-1:0]     mst_isr,
  input logic [N-1:0]     slv_isr
);

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
    ack_req |=> ack_valid);

  p_valid_cause_r9: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(ack_req));

  p_idle_nopend_r4: assert property (@(posedge clk) disable iff (rst)
    (mst_req == '0 && slv_req == '0) |-> !pending);

  p_none_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_vector == '1) |-> ($stable(mst_isr) && $stable(slv_isr)));

  p_one_grant_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(mst_isr ^ $past(mst_isr)) <= 1);

  p_slave_cascade_r7: assert property (@(posedge clk) disable iff (rst)
    (slv_isr != $past(slv_isr)) |-> mst_isr[CASC]);

  p_isr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(ack_req) |-> ($stable(mst_isr) && $stable(slv_isr)));

endmodule

bind cascade_irq_resolver cascade_irq_resolver_chk #(
  .N(N), .CASC(CASC), .VEC_W(VEC_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ack_req   (ack_req),
  .ack_valid (ack_valid),
  .ack_vector(ack_vector),
  .pending   (pending),
  .mst_req   (mst_req),
  .slv_req   (slv_req),
  .mst_isr   (mst_isr),
  .slv_isr   (slv_isr)
);

// File: tb/cascade_irq_resolver_tb_top.sv
`timescale 1ns/1ps
module cascade_irq_resolver_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] line_set = '0, line_clr = '0, level_sel = '0;
  logic [7:0]  mst_mask = '0, slv_mask = '0;
  logic [7:0]  mst_base = 8'h20, slv_base = 8'hFC;
  logic [2:0]  mst_low = 3'd7, slv_low = 3'd7;
  logic        ack_req = 1'b0;
  logic        pending, ack_valid;
  logic [15:0] ack_vector;
  logic [7:0]  mst_req, slv_req, mst_isr, slv_isr;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [7:0]  e_mreq, e_sreq, e_misr, e_sisr;
  bit          e_fm, e_fs, e_valid;
  logic [15:0] e_vec;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  cascade_irq_resolver dut_i (
    .clk(clk), .rst(rst), .line_set(line_set), .line_clr(line_clr),
    .level_sel(level_sel), .mst_mask(mst_mask), .slv_mask(slv_mask),
    .mst_base(mst_base), .slv_base(slv_base), .mst_low(mst_low),
    .slv_low(slv_low), .ack_req(ack_req), .pending(pending),
    .ack_valid(ack_valid), .ack_vector(ack_vector), .mst_req(mst_req),
    .slv_req(slv_req), .mst_isr(mst_isr), .slv_isr(slv_isr)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                     input string tg, input string what);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
    end
  endtask

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // reference model following the requirement text
  task automatic model(input logic [15:0] st, input logic [15:0] cl, input bit ak);
    int  gi;
    bit  gm, gs;
    logic [7:0] mc, sc;
    gm = 0; gs = 0; gi = 0;
    e_valid = ak;
    if (ak) begin
      e_vec = 16'hFFFF;
      if (e_fm || e_fs) begin
        for (int k = 0; k < 8; k++) begin
          int p;
          p = (int'(mst_low) + 1 + k) % 8;
          if (!gm && p != 2 && e_mreq[p] && !mst_mask[p]) begin gm = 1; gi = p; end
        end
        if (!gm)
          for (int k = 0; k < 8; k++) begin
            int p;
            p = (int'(slv_low) + 1 + k) % 8;
            if (!gs && e_sreq[p] && !slv_mask[p]) begin gs = 1; gi = p; end
          end
      end
      if (gm) begin
        e_mreq[gi] = 1'b0; e_misr[gi] = 1'b1;
        e_vec = {8'h00, mst_base} + 16'(gi);
        if (e_mreq == 0) e_fm = 0;
      end else if (gs) begin
        e_sreq[gi] = 1'b0; e_mreq[2] = 1'b0;
        e_sisr[gi] = 1'b1; e_misr[2] = 1'b1;
        e_vec = {8'h00, slv_base} + 16'(gi);
        if (e_sreq == 0) begin e_fs = 0; if (e_mreq == 0) e_fm = 0; end
      end
    end
    mc = cl[7:0] & level_sel[7:0];
    sc = cl[15:8] & level_sel[15:8];
    e_mreq = e_mreq & ~mc;
    e_sreq = e_sreq & ~sc;
    if (sc != 0 && e_sreq == 0) e_mreq[2] = 1'b0;
    e_mreq = e_mreq | st[7:0];
    e_sreq = e_sreq | st[15:8];
    if (st[15:8] != 0) begin e_mreq[2] = 1'b1; e_fs = 1; end
    if (st != 0) e_fm = 1;
  endtask

  task automatic compare(input string tg);
    logic [7:0] mm;
    bit ep;
    mm = e_mreq & ~mst_mask;
    mm[2] = 1'b0;
    ep = (mm != 0) || ((e_sreq & ~slv_mask) != 0);
    chk({8'h0, mst_req}, {8'h0, e_mreq}, tg, "primary request");
    chk({8'h0, slv_req}, {8'h0, e_sreq}, tg, "secondary request");
    chk({8'h0, mst_isr}, {8'h0, e_misr}, "R6/R7", "primary in-service");
    chk({8'h0, slv_isr}, {8'h0, e_sisr}, "R6/R7", "secondary in-service");
    chk({15'h0, pending}, {15'h0, ep}, "R4", "pending");
    chk({15'h0, ack_valid}, {15'h0, e_valid}, "R9", "ack_valid");
    chk(ack_vector, e_vec, (e_vec == 16'hFFFF) ? "R8" : "R5", "vector");
  endtask

  task automatic step(input logic [15:0] st, input logic [15:0] cl,
                      input bit ak, input string tg);
    line_set = st; line_clr = cl; ack_req = ak;
    @(posedge clk);
    model(st, cl, ak);
    @(negedge clk);
    line_set = '0; line_clr = '0; ack_req = 1'b0;
    compare(tg);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    line_set = '0; line_clr = '0; ack_req = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    e_mreq = '0; e_sreq = '0; e_misr = '0; e_sisr = '0;
    e_fm = 0; e_fs = 0; e_valid = 0; e_vec = 16'hFFFF;
    chk({mst_req, slv_req}, 16'h0, "R11", "requests after reset");
    chk({mst_isr, slv_isr}, 16'h0, "R11", "in-service after reset");
    chk({15'h0, ack_valid}, 16'h0, "R11", "ack_valid after reset");
    chk(ack_vector, 16'hFFFF, "R11", "vector after reset");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    // single-line sweep over every pointer: R1 mapping, R5 start point
    for (int lo = 0; lo < 8; lo++) begin
      for (int ln = 0; ln < 16; ln++) begin
        do_reset();
        mst_low = 3'(lo); slv_low = 3'(7 - lo);
        step(16'(1) << ln, '0, 1'b0, "R1");
        step('0, '0, 1'b1, "R5");
        step('0, '0, 1'b1, "R8");
      end
    end

    // full-load drains with masks: R5 wrap-around order, R6, R7
    for (int lo = 0; lo < 8; lo++) begin
      do_reset();
      mst_low = 3'(lo); slv_low = 3'(lo ^ 3);
      next_rand(); mst_mask = lfsr[7:0] & 8'h5A;
      next_rand(); slv_mask = lfsr[15:8] & 8'hA5;
      step(16'hFFFF, '0, 1'b0, "R1");
      for (int a = 0; a < 17; a++) step('0, '0, 1'b1, "R5");
    end
    mst_mask = '0; slv_mask = '0;

    // level versus edge clears: R2
    do_reset();
    level_sel = 16'h00F0;
    step(16'h00FF, '0, 1'b0, "R2");
    step('0, 16'h00FF, 1'b0, "R2");
    chk({8'h0, mst_req}, 16'h000F, "R2", "edge bits held");

    // secondary empties on level clear: R3
    do_reset();
    level_sel = 16'hFF00;
    step(16'h0600, '0, 1'b0, "R3");
    step('0, 16'h0200, 1'b0, "R3");
    chk({8'h0, mst_req}, 16'h0004, "R3", "cascade kept while secondary busy");
    step('0, 16'h0400, 1'b0, "R3");
    chk({mst_req, slv_req}, 16'h0000, "R3", "cascade dropped");

    // ordering inside one cycle: R10
    do_reset();
    level_sel = 16'h0020; mst_low = 3'd7;
    step(16'h0020, '0, 1'b0, "R10");
    step(16'h0020, 16'h0020, 1'b1, "R10");
    chk(ack_vector, 16'h0025, "R10", "granted vector");
    chk({8'h0, mst_req}, 16'h0020, "R10", "request set after grant");

    // pseudo-random mix
    do_reset();
    level_sel = 16'h3C96;
    for (int n = 0; n < 600; n++) begin
      logic [15:0] s, c;
      if (n % 40 == 0) begin
        next_rand(); mst_mask = lfsr[7:0] & lfsr[15:8];
        next_rand(); slv_mask = lfsr[7:0] & lfsr[15:8];
        mst_low = lfsr[2:0]; slv_low = lfsr[5:3];
      end
      next_rand(); s = lfsr;
      next_rand(); s = s & lfsr;
      next_rand(); s = s & lfsr;
      next_rand(); c = lfsr & {lfsr[7:0], lfsr[15:8]};
      next_rand();
      step(s, c, lfsr[0] | lfsr[1], "R10");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule